// File: doc/BRIEF.md
# LIN Master Break and Sync Transmitter

This block is the transmit half of a UART that drives a LIN bus as master. Software starts a message by setting a break-request bit. At the next bit boundary the block holds the serial line dominant (low) for a programmable 13 to 16 bit times. It then releases the line for a one-bit delimiter and sends the sync byte as an ordinary frame: 8 data bits, no parity, one stop bit.

All timing is counted in a baud tick input, and one tick marks one bit time. Bytes go through a transmit data register and a one-entry pending stage into the frame shifter. A transmit-empty flag shows when the data register can accept a byte. The flag reads 0 for the whole break. Software can therefore queue the sync byte as soon as it has requested the break, and the byte goes out right after the delimiter without waiting for an interrupt. A transmit interrupt follows the empty flag when it is enabled.

Top module: `lin_brk_tx`

## Requirements
- R1: Every byte is sent as a start bit (0), then 8 data bits with the least significant bit first, then a stop bit (1). Each bit lasts from one baud tick to the next.
- R2: A control write with `cfg_brk`=1 makes the break begin at the first baud tick after the write. The line is high before that tick.
- R3: The break length comes from `cfg_len` read as a 2-bit binary number {bit1,bit0}: 00 gives 13 bit times, 01 gives 14, 10 gives 15 and 11 gives 16. No queued byte follows when none was written.
- R4: `tx_empty` is 0 from the clock after the break-request write until the break completes. It is 1 again no later than one clock after the break's last bit time, when the data register has been written during the break or not.
- R5: `tx_irq` is high exactly when the interrupt enable from the last control write is 1 and `tx_empty` is 1. It is therefore low during a break and rises when the break completes if enabled.
- R6: A byte written to the data register during a break is sent as the first frame after the break, with no further software action.
- R7: Between the last break bit and the start bit of a queued byte, the line is high for exactly one bit time.
- R8: `brk_busy` (break-request readback) is 1 from the clock after the request write until the break completes, then clears by itself.
- R9: After reset, `sout`=1, `tx_empty`=1, `brk_busy`=0 and `tx_irq`=0.
- R10: A data register write while `tx_empty`=0 outside a break is dropped, and the bytes already accepted are sent in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-clock pulse per bit time |
| cfg_we | input | 1 | Control register write strobe |
| cfg_brk | input | 1 | Break request (1 starts a break) |
| cfg_len | input | 2 | Break length select |
| cfg_ien | input | 1 | Transmit interrupt enable |
| tdr_we | input | 1 | Transmit data register write strobe |
| tdr_data | input | 8 | Byte to transmit |
| sout | output | 1 | Serial output, idle high |
| brk_busy | output | 1 | Break request readback |
| tx_empty | output | 1 | Transmit data register can accept a byte |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Directed breaks go through all four length codes with and without a queued sync byte. The bench measures the dominant run on the line, which separates the length decode from off-by-one counting. It also counts the high bits before the start bit, which exposes a missing or doubled delimiter. Randomised breaks mix the length, the queued byte value and the interrupt enable, so that flag timing and data ordering are checked together. A back-to-back stream with an extra write into a full register shows whether the buffering drops the right byte and keeps the LSB-first order.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;
    localparam int DATA_W     = 8;
    localparam int LEN_W      = 2;
    localparam int BRK_BASE   = 13;
    localparam int BRK_MAX    = BRK_BASE + (2 ** LEN_W) - 1;
    localparam int CNT_W      = $clog2(BRK_MAX + 1);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_BREAK = 2'd1,
        LN_DELIM = 2'd2,
        LN_FRAME = 2'd3
    } line_st_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             ien;
    } tx_cfg_t;

    function automatic logic [CNT_W-1:0] brk_ticks(input logic [LEN_W-1:0] sel);
        return CNT_W'(BRK_BASE) + CNT_W'(sel);
    endfunction
endpackage

// File: rtl/lin_tx_regs.sv
module lin_tx_regs
    import lin_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_brk,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_ien,
    input  logic              tdr_we,
    input  logic [DATA_W-1:0] tdr_data,
    input  logic              line_brk,
    input  logic              brk_taken,
    input  logic              take,
    output tx_cfg_t           cfg_q,
    output logic              brk_pend,
    output logic              brk_busy,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data,
    output logic              tx_empty,
    output logic              tx_irq
);
    assign brk_busy = brk_pend | line_brk;
    assign tx_empty = ~hold_full & ~brk_busy;
    assign tx_irq   = cfg_q.ien & tx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            brk_pend <= 1'b0;
        end else begin
            if (cfg_we) begin
                cfg_q.len <= cfg_len;
                cfg_q.ien <= cfg_ien;
            end
            if (brk_taken)
                brk_pend <= 1'b0;
            else if (cfg_we && cfg_brk && !brk_busy)
                brk_pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (tdr_we && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= tdr_data;
        end
    end

    // R10: an accepted byte stays unchanged until the sequencer takes it
    p_hold_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !take) |=> (hold_full && $stable(hold_data)));

    // R8: a request is only consumed by a break start
    p_req_consumed_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_pend) |-> line_brk);
endmodule

// File: rtl/lin_tx_seq.sv
module lin_tx_seq
    import lin_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              brk_pend,
    input  logic              brk_busy,
    input  logic [LEN_W-1:0]  brk_len,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              brk_taken,
    output logic              take,
    output logic              line_brk,
    output line_st_t          state_o,
    output logic              sout
);
    line_st_t          state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              pend_valid;
    logic [DATA_W-1:0] pend_data;
    logic              frame_last;
    logic              boundary;

    assign frame_last = (idx == IDX_W'(FRAME_BITS - 1));
    assign boundary   = tick && ((state == LN_IDLE) || (state == LN_DELIM) ||
                                 ((state == LN_FRAME) && frame_last));
    assign brk_taken  = boundary && brk_pend;
    assign take       = hold_full && !pend_valid && !brk_busy;
    assign line_brk   = (state == LN_BREAK);
    assign state_o    = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= LN_IDLE;
            cnt        <= '0;
            idx        <= '0;
            shreg      <= '0;
            pend_valid <= 1'b0;
            pend_data  <= '0;
        end else begin
            if (take) begin
                pend_valid <= 1'b1;
                pend_data  <= hold_data;
            end
            if (boundary) begin
                if (brk_pend) begin
                    state <= LN_BREAK;
                    cnt   <= brk_ticks(brk_len) - CNT_W'(1);
                end else if (pend_valid) begin
                    state      <= LN_FRAME;
                    idx        <= '0;
                    shreg      <= pend_data;
                    pend_valid <= 1'b0;
                end else begin
                    state <= LN_IDLE;
                end
            end else if (tick) begin
                case (state)
                    LN_BREAK: begin
                        if (cnt == '0)
                            state <= LN_DELIM;
                        else
                            cnt <= cnt - CNT_W'(1);
                    end
                    LN_FRAME: begin
                        if (idx != '0)
                            shreg <= shreg >> 1;
                        idx <= idx + IDX_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (state)
            LN_BREAK: sout = 1'b0;
            LN_FRAME: begin
                if (idx == '0)
                    sout = 1'b0;
                else if (frame_last)
                    sout = 1'b1;
                else
                    sout = shreg[0];
            end
            default:  sout = 1'b1;
        endcase
    end

    // independent tick count of the dominant period, used by the length check
    logic [CNT_W-1:0] seen_ticks;
    logic [CNT_W-1:0] want_ticks;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_ticks <= '0;
            want_ticks <= '0;
        end else if (brk_taken) begin
            seen_ticks <= '0;
            want_ticks <= brk_ticks(brk_len);
        end else if (tick && line_brk) begin
            seen_ticks <= seen_ticks + CNT_W'(1);
        end
    end

    // R3: the break ends after exactly the selected number of bit times
    p_brk_len_r3: assert property (@(posedge clk) disable iff (rst)
        (line_brk && tick && cnt == '0) |-> (seen_ticks + CNT_W'(1) == want_ticks));

    // R7: a frame never starts straight out of the dominant period
    p_delim_r7: assert property (@(posedge clk) disable iff (rst)
        (state == LN_FRAME && $past(state) != LN_FRAME) |-> ($past(state) != LN_BREAK));

    // R10: the pending stage is only loaded when free
    p_one_take_r10: assert property (@(posedge clk) disable iff (rst)
        take |-> !pend_valid);
endmodule

// File: rtl/lin_brk_tx.sv
module lin_brk_tx
    import lin_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              cfg_we,
    input  logic              cfg_brk,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_ien,
    input  logic              tdr_we,
    input  logic [DATA_W-1:0] tdr_data,
    output logic              sout,
    output logic              brk_busy,
    output logic              tx_empty,
    output logic              tx_irq
);
    tx_cfg_t           cfg_q;
    logic              brk_pend;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              line_brk;
    logic              brk_taken;
    logic              take;
    line_st_t          line_st;

    lin_tx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_brk   (cfg_brk),
        .cfg_len   (cfg_len),
        .cfg_ien   (cfg_ien),
        .tdr_we    (tdr_we),
        .tdr_data  (tdr_data),
        .line_brk  (line_brk),
        .brk_taken (brk_taken),
        .take      (take),
        .cfg_q     (cfg_q),
        .brk_pend  (brk_pend),
        .brk_busy  (brk_busy),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .tx_empty  (tx_empty),
        .tx_irq    (tx_irq)
    );

    lin_tx_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .brk_pend  (brk_pend),
        .brk_busy  (brk_busy),
        .brk_len   (cfg_q.len),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .brk_taken (brk_taken),
        .take      (take),
        .line_brk  (line_brk),
        .state_o   (line_st),
        .sout      (sout)
    );

    // R4: the empty flag stays low while the line is dominant
    p_empty_low_r4: assert property (@(posedge clk) disable iff (rst)
        line_brk |-> !tx_empty);

    // R8: the request readback clears only as the break hands over to the delimiter
    p_selfclear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_busy) |-> (line_st == LN_DELIM));

    // R5: an enabled interrupt accompanies the empty flag's return
    p_irq_rise_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_empty) && cfg_q.ien) |-> tx_irq);

    // R2: the line is low whenever a break is running
    p_brk_low_r2: assert property (@(posedge clk) disable iff (rst)
        (brk_busy && !brk_pend) |-> !sout);
endmodule

// File: tb/sim_lin_brk_tx.sv
`timescale 1ns/100ps
module sim_lin_brk_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_brk = 1'b0;
    logic [1:0] cfg_len = 2'd0;
    logic       cfg_ien = 1'b0;
    logic       tdr_we = 1'b0;
    logic [7:0] tdr_data = 8'd0;
    logic       sout, brk_busy, tx_empty, tx_irq;

    int  n_run = 0;
    int  n_fail = 0;
    bit  lg [0:1023];
    int  lg_n = 0;
    bit  rec = 1'b0;
    int  tdiv = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    lin_brk_tx u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .cfg_we(cfg_we),
        .cfg_brk(cfg_brk), .cfg_len(cfg_len), .cfg_ien(cfg_ien),
        .tdr_we(tdr_we), .tdr_data(tdr_data), .sout(sout),
        .brk_busy(brk_busy), .tx_empty(tx_empty), .tx_irq(tx_irq)
    );

    initial begin
        forever begin
            @(negedge clk);
            tdiv = (tdiv + 1) % 8;
            baud_tick = (tdiv == 0);
        end
    end

    always begin
        @(negedge clk);
        #1;
        if (rec && baud_tick && lg_n < 1024) begin
            lg[lg_n] = sout;
            lg_n++;
        end
    end

    function automatic int exp_brk(input int sel);
        return 13 + sel;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic smp();
        @(negedge clk);
        #1;
    endtask

    task automatic cfg_wr(input bit b, input int l, input bit ie);
        @(negedge clk);
        cfg_we = 1'b1; cfg_brk = b; cfg_len = 2'(l); cfg_ien = ie;
        @(negedge clk);
        cfg_we = 1'b0; cfg_brk = 1'b0;
        #1;
    endtask

    task automatic tdr_wr(input logic [7:0] v);
        @(negedge clk);
        tdr_we = 1'b1; tdr_data = v;
        @(negedge clk);
        tdr_we = 1'b0;
        #1;
    endtask

    task automatic run_break(input int sel, input bit queue, input logic [7:0] val, input bit ie);
        int i, z, o;
        logic [7:0] d;
        lg_n = 0;
        rec = 1'b1;
        cfg_wr(1'b1, sel, ie);
        chk("R8 busy after request", int'(brk_busy), 1);
        chk("R4 empty low after request", int'(tx_empty), 0);
        chk("R5 irq low in break", int'(tx_irq), 0);
        if (queue) begin
            tdr_wr(val);
            chk("R4 empty low with queued byte", int'(tx_empty), 0);
        end
        while (brk_busy) smp();
        smp();
        chk("R4 empty back after break", int'(tx_empty), 1);
        chk("R5 irq follows enable", int'(tx_irq), int'(ie));
        repeat (14 * 8) smp();
        rec = 1'b0;
        i = 0;
        while (i < lg_n && lg[i]) i++;
        chk("R2 break starts at next tick", i, 1);
        z = 0;
        while (i < lg_n && !lg[i]) begin z++; i++; end
        chk("R3 break length", z, exp_brk(sel));
        o = 0;
        while (i < lg_n && lg[i]) begin o++; i++; end
        if (queue) begin
            chk("R7 delimiter length", o, 1);
            i++;
            d = 8'd0;
            for (int k = 0; k < 8; k++) d[k] = (i + k < lg_n) ? lg[i + k] : 1'b0;
            chk("R6 queued byte after break", int'(d), int'(val));
            chk("R1 stop bit", (i + 8 < lg_n) ? int'(lg[i + 8]) : -1, 1);
        end else begin
            chk("R3 no frame without queued byte", i, lg_n);
        end
    endtask

    task automatic decode(output int cnt, output logic [7:0] got [0:7]);
        int i;
        cnt = 0;
        i = 0;
        while (i < lg_n) begin
            if (lg[i]) begin
                i++;
            end else if (i + 9 < lg_n && cnt < 8) begin
                for (int k = 0; k < 8; k++) got[cnt][k] = lg[i + 1 + k];
                chk("R1 frame stop bit", int'(lg[i + 9]), 1);
                cnt++;
                i += 10;
            end else begin
                i = lg_n;
            end
        end
    endtask

    task automatic wait_empty();
        while (!tx_empty) smp();
    endtask

    initial begin
        int cnt;
        logic [7:0] got [0:7];
        logic [7:0] ref_b [0:7];
        void'($urandom(32'h1a5c0de));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        smp();
        chk("R9 reset sout", int'(sout), 1);
        chk("R9 reset empty", int'(tx_empty), 1);
        chk("R9 reset busy", int'(brk_busy), 0);
        chk("R9 reset irq", int'(tx_irq), 0);

        for (int s = 0; s < 4; s++) run_break(s, 1'b0, 8'h00, 1'b0);
        for (int s = 0; s < 4; s++) run_break(s, 1'b1, 8'h55, 1'b1);

        for (int n = 0; n < 6; n++)
            run_break(int'($urandom_range(3)), 1'(($urandom_range(1))),
                      8'($urandom_range(255)), 1'(($urandom_range(1))));

        // R1 stream of random bytes, written whenever the register is empty
        lg_n = 0; rec = 1'b1;
        cfg_wr(1'b0, 0, 1'b0);
        for (int n = 0; n < 5; n++) begin
            ref_b[n] = 8'($urandom_range(255));
            wait_empty();
            tdr_wr(ref_b[n]);
        end
        repeat (60 * 8) smp();
        rec = 1'b0;
        decode(cnt, got);
        chk("R1 stream frame count", cnt, 5);
        for (int n = 0; n < 5; n++) chk("R1 stream byte LSB first", int'(got[n]), int'(ref_b[n]));

        // R10 extra write into a full register is dropped
        lg_n = 0; rec = 1'b1;
        ref_b[0] = 8'hA3; ref_b[1] = 8'h0F; ref_b[2] = 8'hC8;
        for (int n = 0; n < 3; n++) begin
            wait_empty();
            tdr_wr(ref_b[n]);
        end
        chk("R10 register full", int'(tx_empty), 0);
        tdr_wr(8'h3C);
        repeat (50 * 8) smp();
        rec = 1'b0;
        decode(cnt, got);
        chk("R10 dropped write frame count", cnt, 3);
        for (int n = 0; n < 3; n++) chk("R10 kept byte order", int'(got[n]), int'(ref_b[n]));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule